// File: doc/BRIEF.md
# Masked interrupt flag controller

This block holds the pending-interrupt state of a small 8-bit microcontroller. Three hardware sources raise pending bits in an 8-bit flag register: a timer overflow pulse, a change of level on any enabled port pin, and a falling edge on the external interrupt pin. The core's software can clear pending bits through a register port but can never raise them. A separate 8-bit mask register selects which pending bits may interrupt. A global enable bit, driven by instruction strobes from the core, decides whether an interrupt request is presented at all.

The core reads the flag register through the mask, so a masked-off bit reads as zero. It sees `irq_req` whenever the global enable is set and a masked pending bit exists. When it accepts the interrupt it pulses `irq_take`, which drops the global enable until the return instruction sets it again. A port-pin change also drives `wake`, which a sleep controller can use whatever the mask or the global enable hold.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears all flag bits, the mask register and the global enable, so `irq_req` and `wake` read 0 and both register addresses read 0x00.
- R2: Flag bit 2 is set when `ext_pin` goes from high to low. The flag becomes visible 3 clock edges after the pin changes, because the pin passes a two-flop synchronizer and then an edge detector. A low-to-high transition sets nothing.
- R3: A one-cycle high on `tmr_ovf` sets flag bit 0 at the next clock edge.
- R4: A change of level in either direction on a port pin whose `port_en` bit is 1 sets flag bit 1, visible 3 clock edges after the change. Changes on pins whose `port_en` bit is 0 set nothing.
- R5: A write to address 0 (flag register) clears each flag bit whose data bit is 0 and leaves each flag bit whose data bit is 1 unchanged. A write never sets a flag. Flag bits 7 to 3 always stay 0.
- R6: A write to address 1 stores all 8 data bits in the mask register, and address 1 reads the mask back. Address 0 reads the flags ANDed bitwise with the mask. The read path is combinational.
- R7: When a hardware event sets a flag bit in the same cycle that a flag write would clear it, the bit ends up set.
- R8: The global enable is set by `ins_eni` or `ins_reti` and cleared by `ins_disi` or `irq_take`. When a set and a clear arrive in the same cycle, the clear wins.
- R9: `irq_req` is 1 exactly when the global enable is 1 and the flags ANDed with the mask are non-zero.
- R10: `wake` is 1 while flag bit 1 (port change) is set, regardless of the mask and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 1 | Register select: 0 flags, 1 mask |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | NPORT | Port pins watched for level changes, asynchronous |
| port_en | input | NPORT | Per-pin change-detect enable |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| ins_eni | input | 1 | Enable-interrupt instruction strobe |
| ins_disi | input | 1 | Disable-interrupt instruction strobe |
| ins_reti | input | 1 | Return-from-interrupt instruction strobe |
| irq_take | input | 1 | Core accepts the interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request from a port change |

## Verification
The assertions assume that `tmr_ovf`, the instruction strobes, `irq_take` and the register inputs are synchronous to `clk`. The pins may move at any time, but each new pin level must last at least two clock cycles so the synchronizer captures it. The stimulus drives every input only on falling clock edges. It holds each pin level for three or more cycles, and it keeps the port pins at a fixed level through reset so the warm-up window is exercised with quiet inputs.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int FLAG_W   = 8;
    localparam int BIT_TMR  = 0;
    localparam int BIT_PORT = 1;
    localparam int BIT_EXT  = 2;

    localparam logic [FLAG_W-1:0] HW_BITS =
        FLAG_W'((1 << BIT_TMR) | (1 << BIT_PORT) | (1 << BIT_EXT));

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_MASK = 1'b1
    } regsel_e;

    typedef struct packed {
        logic ext;
        logic port;
        logic tmr;
    } hw_evt_t;

    typedef enum logic [1:0] {
        GIE_HOLD = 2'd0,
        GIE_SET  = 2'd1,
        GIE_CLR  = 2'd2
    } gie_op_e;

    function automatic logic [FLAG_W-1:0] evt_to_vec(hw_evt_t e);
        logic [FLAG_W-1:0] v;
        v           = '0;
        v[BIT_TMR]  = e.tmr;
        v[BIT_PORT] = e.port;
        v[BIT_EXT]  = e.ext;
        return v;
    endfunction

    // Clearing sources dominate setting sources.
    function automatic gie_op_e gie_decode(logic set_any, logic clr_any);
        if (clr_any)      return GIE_CLR;
        else if (set_any) return GIE_SET;
        else              return GIE_HOLD;
    endfunction

endpackage

// File: rtl/irqf_edge.sv
module irqf_edge
    import irqf_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic [NPORT-1:0] port_pins,
    input  logic [NPORT-1:0] port_en,
    output logic             ext_fall,
    output logic             port_chg
);
    localparam int NSIG = NPORT + 1;

    logic [NSIG-1:0] s1, s2, s3;
    logic [1:0]      warm;
    logic            armed;

    // Two synchronizing stages plus one history stage per watched line.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            s3   <= '0;
            warm <= '0;
        end else begin
            s1 <= {ext_pin, port_pins};
            s2 <= s1;
            s3 <= s2;
            if (warm != 2'd3) warm <= warm + 2'd1;
        end
    end

    // History holds real pin data only after three edges out of reset.
    assign armed    = (warm == 2'd3);
    assign ext_fall = armed & s3[NPORT] & ~s2[NPORT];
    assign port_chg = armed & |((s2[NPORT-1:0] ^ s3[NPORT-1:0]) & port_en);

    // R2: a single falling edge is reported for one cycle only
    a_r2_fall_single: assert property (@(posedge clk) disable iff (rst)
        ext_fall |=> !ext_fall);

endmodule

// File: rtl/irqf_flags.sv
module irqf_flags
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] keep_bits,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] kept;

    assign kept = clr_en ? (flags & keep_bits) : flags;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (kept | set_vec) & HW_BITS;
    end

    // R5: a bit rises only where hardware asked for it
    a_r5_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

    // R7: a requested set always lands, even against a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R5: unimplemented flag bits stay low
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (flags & ~HW_BITS) == '0);

endmodule

// File: rtl/irqf_gie.sv
module irqf_gie
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ins_eni,
    input  logic ins_reti,
    input  logic ins_disi,
    input  logic irq_take,
    output logic gie
);
    gie_op_e op;

    assign op = gie_decode(ins_eni | ins_reti, ins_disi | irq_take);

    always_ff @(posedge clk) begin
        if (rst) begin
            gie <= 1'b0;
        end else begin
            case (op)
                GIE_SET:  gie <= 1'b1;
                GIE_CLR:  gie <= 1'b0;
                default:  gie <= gie;
            endcase
        end
    end

    // R8: taking or disabling always leaves the enable low
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (ins_disi || irq_take) |=> !gie);

    // R8: an uncontested enable or return sets the enable
    a_r8_set: assert property (@(posedge clk) disable iff (rst)
        ((ins_eni || ins_reti) && !ins_disi && !irq_take) |=> gie);

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqf_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ext_pin,
    input  logic [NPORT-1:0] port_pins,
    input  logic [NPORT-1:0] port_en,
    input  logic             tmr_ovf,
    input  logic             ins_eni,
    input  logic             ins_disi,
    input  logic             ins_reti,
    input  logic             irq_take,
    output logic             irq_req,
    output logic             wake
);
    regsel_e           sel;
    hw_evt_t           evt;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] mask_q;
    logic [FLAG_W-1:0] pending;
    logic              gie;
    logic              ext_fall;
    logic              port_chg;

    assign sel = regsel_e'(reg_addr);

    irqf_edge #(.NPORT(NPORT)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .ext_pin   (ext_pin),
        .port_pins (port_pins),
        .port_en   (port_en),
        .ext_fall  (ext_fall),
        .port_chg  (port_chg)
    );

    assign evt.ext  = ext_fall;
    assign evt.port = port_chg;
    assign evt.tmr  = tmr_ovf;

    irqf_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (evt_to_vec(evt)),
        .clr_en    (reg_wr && sel == SEL_FLAG),
        .keep_bits (reg_wdata),
        .flags     (flags)
    );

    irqf_gie u_gie (
        .clk      (clk),
        .rst      (rst),
        .ins_eni  (ins_eni),
        .ins_reti (ins_reti),
        .ins_disi (ins_disi),
        .irq_take (irq_take),
        .gie      (gie)
    );

    always_ff @(posedge clk) begin
        if (rst)                            mask_q <= '0;
        else if (reg_wr && sel == SEL_MASK) mask_q <= reg_wdata;
    end

    assign pending   = flags & mask_q;
    assign reg_rdata = (sel == SEL_MASK) ? mask_q : pending;
    assign irq_req   = gie & (|pending);
    assign wake      = flags[BIT_PORT];

    // R9: no request without the global enable
    a_r9_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> gie);

    // R10: wake only rises after a detected port change
    a_r10_wake_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> $past(port_chg));

endmodule

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;

    localparam int NPORT = 4;
    localparam int NVEC  = 16;

    // Vector: [23:22] op (0 write, 1 read-check, 2 timer pulse),
    // [21] addr, [20:17] requirement number, [15:8] data, [7:0] expected.
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd1, 1'b0, 4'd1, 1'b0, 8'h00, 8'h00},  // R1 flags after reset
        {2'd1, 1'b1, 4'd1, 1'b0, 8'h00, 8'h00},  // R1 mask after reset
        {2'd0, 1'b1, 4'd6, 1'b0, 8'hFF, 8'h00},
        {2'd1, 1'b1, 4'd6, 1'b0, 8'h00, 8'hFF},  // R6 mask read back
        {2'd2, 1'b0, 4'd3, 1'b0, 8'h00, 8'h00},
        {2'd1, 1'b0, 4'd3, 1'b0, 8'h00, 8'h01},  // R3 timer flag
        {2'd0, 1'b0, 4'd5, 1'b0, 8'hFF, 8'h00},
        {2'd1, 1'b0, 4'd5, 1'b0, 8'h00, 8'h01},  // R5 ones keep
        {2'd0, 1'b1, 4'd6, 1'b0, 8'hFE, 8'h00},
        {2'd1, 1'b0, 4'd6, 1'b0, 8'h00, 8'h00},  // R6 masked read
        {2'd0, 1'b1, 4'd6, 1'b0, 8'hFF, 8'h00},
        {2'd1, 1'b0, 4'd6, 1'b0, 8'h00, 8'h01},
        {2'd0, 1'b0, 4'd5, 1'b0, 8'hFE, 8'h00},
        {2'd1, 1'b0, 4'd5, 1'b0, 8'h00, 8'h00},  // R5 zero clears
        {2'd0, 1'b0, 4'd5, 1'b0, 8'hFF, 8'h00},
        {2'd1, 1'b0, 4'd5, 1'b0, 8'h00, 8'h00}   // R5 never sets
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             reg_addr;
    logic             reg_wr;
    logic [7:0]       reg_wdata;
    logic [7:0]       reg_rdata;
    logic             ext_pin;
    logic [NPORT-1:0] port_pins;
    logic [NPORT-1:0] port_en;
    logic             tmr_ovf;
    logic             ins_eni;
    logic             ins_disi;
    logic             ins_reti;
    logic             irq_take;
    logic             irq_req;
    logic             wake;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_flag_ctrl #(.NPORT(NPORT)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .port_pins(port_pins), .port_en(port_en), .tmr_ovf(tmr_ovf),
        .ins_eni(ins_eni), .ins_disi(ins_disi), .ins_reti(ins_reti),
        .irq_take(irq_take), .irq_req(irq_req), .wake(wake)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        ext_pin = 1'b1; port_pins = '0; port_en = 4'b0010; tmr_ovf = 1'b0;
        ins_eni = 1'b0; ins_disi = 1'b0; ins_reti = 1'b0; irq_take = 1'b0;
        edges(3);
        rst = 1'b0;
        edges(4);
        check("R1 irq_req", {7'd0, irq_req}, 8'h00);
        check("R1 wake", {7'd0, wake}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][23:22])
                2'd0: wr(VEC[i][21], VEC[i][15:8]);
                2'd1: rd($sformatf("R%0d vector %0d", VEC[i][20:17], i),
                         VEC[i][21], VEC[i][7:0]);
                default: begin
                    tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
                end
            endcase
        end

        // R2: falling edge appears after exactly 3 edges
        ext_pin = 1'b0;
        edges(2);
        rd("R2 before 3rd edge", 1'b0, 8'h00);
        edges(1);
        rd("R2 falling edge", 1'b0, 8'h04);
        wr(1'b0, 8'hFB);
        ext_pin = 1'b1;
        edges(5);
        rd("R2 rising ignored", 1'b0, 8'h00);

        // R9 / R8: request gating by the global enable
        tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        check("R9 gie off", {7'd0, irq_req}, 8'h00);
        ins_eni = 1'b1; @(negedge clk); ins_eni = 1'b0;
        check("R8 eni sets", {7'd0, irq_req}, 8'h01);
        wr(1'b1, 8'h00);
        check("R9 masked", {7'd0, irq_req}, 8'h00);
        wr(1'b1, 8'hFF);
        check("R9 unmasked", {7'd0, irq_req}, 8'h01);
        irq_take = 1'b1; @(negedge clk); irq_take = 1'b0;
        check("R8 take clears", {7'd0, irq_req}, 8'h00);
        ins_reti = 1'b1; @(negedge clk); ins_reti = 1'b0;
        check("R8 reti sets", {7'd0, irq_req}, 8'h01);
        ins_eni = 1'b1; ins_disi = 1'b1; @(negedge clk);
        ins_eni = 1'b0; ins_disi = 1'b0;
        check("R8 clear wins", {7'd0, irq_req}, 8'h00);
        ins_eni = 1'b1; @(negedge clk); ins_eni = 1'b0;
        wr(1'b0, 8'hFE);
        check("R9 no pending", {7'd0, irq_req}, 8'h00);

        // R7: hardware set beats a same-cycle clear
        tmr_ovf = 1'b1;
        wr(1'b0, 8'h00);
        tmr_ovf = 1'b0;
        rd("R7 set wins", 1'b0, 8'h01);
        wr(1'b0, 8'h00);
        ins_disi = 1'b1; @(negedge clk); ins_disi = 1'b0;

        // R4: disabled pin ignored, enabled pin flagged
        port_pins[0] = 1'b1;
        edges(4);
        rd("R4 disabled pin", 1'b0, 8'h00);
        check("R10 no wake", {7'd0, wake}, 8'h00);
        wr(1'b1, 8'h00);
        port_pins[1] = 1'b1;
        edges(3);
        check("R10 wake with mask 0", {7'd0, wake}, 8'h01);
        check("R9 masked port", {7'd0, irq_req}, 8'h00);
        wr(1'b1, 8'hFF);
        rd("R4 rise flagged", 1'b0, 8'h02);
        wr(1'b0, 8'hFD);
        check("R10 wake clears", {7'd0, wake}, 8'h00);
        port_pins[1] = 1'b0;
        edges(3);
        rd("R4 fall flagged", 1'b0, 8'h02);

        // R1: reset with state present
        tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        ins_eni = 1'b1; @(negedge clk); ins_eni = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd("R1 flags cleared", 1'b0, 8'h00);
        rd("R1 mask cleared", 1'b1, 8'h00);
        check("R1 wake low", {7'd0, wake}, 8'h00);
        wr(1'b1, 8'hFF);
        tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        check("R1 gie cleared", {7'd0, irq_req}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule